// File: doc/BRIEF.md
# Inbound Request Address Translation Bridge

This block sits behind the receive side of a serial link. Requests arrive already decoded. Each one carries the following:

- a direction (read or write);
- the index of the address region it hit;
- an address;
- a length in data beats;
- a tag;
- one flag marking it as malformed (for a write) or unsupported (for a read).

The bridge turns each good request into one or more burst commands on a local memory-mapped master port.

In endpoint mode the high part of the local address comes from a small lookup table. The table is indexed by the region hit and is loaded through a configuration write port before traffic starts. The low offset bits of the request address pass through untouched. In root mode the lookup table is bypassed and the request address is forwarded exactly as received.

A flagged write vanishes without any trace on the master port. A flagged read does not reach the bus either: it raises a one-cycle abort pulse carrying its tag, which the completion logic uses. A good write becomes a single burst. A good read is cut into bursts of at most 512 bytes, each continuing where the previous one ended.

The bridge holds one command at a time. It accepts a new request only when that command slot is empty. While the local bus asserts its wait signal, the command on the port holds still.

Top module: `req_xlate_bridge`

## Requirements
- R1: After a synchronous reset, m_valid and abort_valid are low and req_ready is high.
- R2: In endpoint mode (mode_root low), a good request's m_addr is the table entry selected by req_region (cfg_idx written with cfg_upper while cfg_we is high) in bits 31:20, concatenated with req_addr bits 19:0. The first command is valid in the cycle after acceptance.
- R3: In root mode (mode_root high), m_addr of the first burst equals req_addr exactly, whatever req_region is.
- R4: An accepted write with req_bad high produces no command and no abort pulse, and req_ready stays high.
- R5: An accepted read with req_bad high produces no command, and abort_valid is high for exactly the one cycle after acceptance, with abort_tag equal to req_tag.
- R6: A good write yields one command with m_write high and m_burst equal to req_beats, whatever the length.
- R7: A good read of at most 128 beats (512 bytes at 4 bytes per beat) yields one command with m_write low and m_burst equal to req_beats.
- R8: A longer read yields consecutive bursts of 128 beats with a final remainder burst. Each burst address is the previous burst address plus 4 times its beat count, and every burst carries req_tag on m_tag.
- R9: While m_valid and m_wait are high, m_addr, m_burst, m_write and m_tag hold their values and m_valid stays high.
- R10: req_ready is low whenever a command is outstanding on the master port.
- R11: Aborts for flagged reads accepted on consecutive cycles appear on consecutive cycles, in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_root | input | 1 | 1: pass addresses through; 0: translate through the table |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | 3 | Table entry to write |
| cfg_upper | input | 12 | Upper address field for the entry |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request slot free; acceptance is req_valid and req_ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_region | input | 3 | Address region hit index |
| req_addr | input | 32 | Request byte address |
| req_beats | input | 10 | Length in 4-byte beats, nonzero |
| req_tag | input | 8 | Request tag |
| req_bad | input | 1 | Malformed write or unsupported read |
| m_valid | output | 1 | Command valid on master port |
| m_write | output | 1 | Command is a burst write |
| m_addr | output | 32 | Command local byte address |
| m_burst | output | 10 | Command burst length in beats |
| m_tag | output | 8 | Tag of the originating request |
| m_wait | input | 1 | Local bus stall |
| abort_valid | output | 1 | One-cycle completer-abort pulse |
| abort_tag | output | 8 | Tag of the aborted read |

## Verification
The hardest situation to reach is a long read whose split bursts meet local bus stalls at several points. The address must advance correctly across burst boundaries even though the handshake slips by different amounts on each burst.

The directed stimulus drives a 300-beat read and a read of exactly 256 beats. It holds m_wait high for a chosen number of cycles on each burst before releasing it, and checks that the outputs stay frozen and req_ready stays low during those stalls.

The back-to-back abort case needs req_valid held through two consecutive edges with different tags. A dedicated task drives it that way.

// File: rtl/xb_pkg.sv
package xb_pkg;
  parameter int XB_ADDR_W     = 32;
  parameter int XB_OFFSET_W   = 20;
  parameter int XB_REGIONS    = 8;
  parameter int XB_BEATS_W    = 10;
  parameter int XB_TAG_W      = 8;
  parameter int XB_DATA_BYTES = 4;
  parameter int XB_MAX_BYTES  = 512;

  typedef enum logic [1:0] {
    DISP_CMD   = 2'd0,
    DISP_DROP  = 2'd1,
    DISP_ABORT = 2'd2
  } disp_e;
endpackage

// File: rtl/xb_xlate_table.sv
module xb_xlate_table #(
  parameter int ADDR_W   = xb_pkg::XB_ADDR_W,
  parameter int OFFSET_W = xb_pkg::XB_OFFSET_W,
  parameter int REGIONS  = xb_pkg::XB_REGIONS,
  localparam int UP_W    = ADDR_W - OFFSET_W,
  localparam int IDX_W   = $clog2(REGIONS)
) (
  input  logic              clk,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [UP_W-1:0]   cfg_upper,
  input  logic              root_mode,
  input  logic [IDX_W-1:0]  region,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);
  // Small table, written once before traffic; inferred as distributed RAM.
  logic [UP_W-1:0] mem [REGIONS];

  always_ff @(posedge clk) begin
    if (cfg_we) mem[cfg_idx] <= cfg_upper;
  end

  always_comb begin
    if (root_mode) addr_out = addr_in;
    else           addr_out = {mem[region], addr_in[OFFSET_W-1:0]};
  end
endmodule

// File: rtl/xb_cmd_seq.sv
module xb_cmd_seq #(
  parameter int ADDR_W     = xb_pkg::XB_ADDR_W,
  parameter int BEATS_W    = xb_pkg::XB_BEATS_W,
  parameter int TAG_W      = xb_pkg::XB_TAG_W,
  parameter int DATA_BYTES = xb_pkg::XB_DATA_BYTES,
  parameter int MAX_BYTES  = xb_pkg::XB_MAX_BYTES,
  localparam int MAX_BEATS = MAX_BYTES / DATA_BYTES,
  localparam int BYTE_SH   = $clog2(DATA_BYTES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               ld_write,
  input  logic [ADDR_W-1:0]  ld_addr,
  input  logic [BEATS_W-1:0] ld_beats,
  input  logic [TAG_W-1:0]   ld_tag,
  input  logic               m_wait,
  output logic               m_valid,
  output logic               m_write,
  output logic [ADDR_W-1:0]  m_addr,
  output logic [BEATS_W-1:0] m_burst,
  output logic [TAG_W-1:0]   m_tag
);
  localparam logic [BEATS_W-1:0] CAP = BEATS_W'(MAX_BEATS);

  logic [BEATS_W-1:0] rest;       // beats left after the burst on the port
  logic [BEATS_W-1:0] ld_chunk;
  logic [BEATS_W-1:0] nx_chunk;
  logic               fire;

  assign fire     = m_valid && !m_wait;
  assign ld_chunk = (!ld_write && ld_beats > CAP) ? CAP : ld_beats;
  assign nx_chunk = (rest > CAP) ? CAP : rest;

  always_ff @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0;
      m_write <= 1'b0;
      m_addr  <= '0;
      m_burst <= '0;
      m_tag   <= '0;
      rest    <= '0;
    end else if (load) begin
      m_valid <= 1'b1;
      m_write <= ld_write;
      m_addr  <= ld_addr;
      m_burst <= ld_chunk;
      m_tag   <= ld_tag;
      rest    <= ld_beats - ld_chunk;
    end else if (fire) begin
      if (rest == '0) begin
        m_valid <= 1'b0;
      end else begin
        m_addr  <= m_addr + (ADDR_W'(m_burst) << BYTE_SH);
        m_burst <= nx_chunk;
        rest    <= rest - nx_chunk;
      end
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (m_valid && m_wait) |=> (m_valid && $stable(m_addr) && $stable(m_burst)
                             && $stable(m_write) && $stable(m_tag)));

  p_cap_r7: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_write) |-> (m_burst != '0 && m_burst <= CAP));

  p_contig_r8: assert property (@(posedge clk) disable iff (rst)
    fire |=> (!m_valid || (!m_write && $stable(m_tag) &&
              m_addr == $past(m_addr) + (ADDR_W'($past(m_burst)) << BYTE_SH))));
endmodule

// File: rtl/req_xlate_bridge.sv
module req_xlate_bridge #(
  parameter int ADDR_W     = xb_pkg::XB_ADDR_W,
  parameter int OFFSET_W   = xb_pkg::XB_OFFSET_W,
  parameter int REGIONS    = xb_pkg::XB_REGIONS,
  parameter int BEATS_W    = xb_pkg::XB_BEATS_W,
  parameter int TAG_W      = xb_pkg::XB_TAG_W,
  parameter int DATA_BYTES = xb_pkg::XB_DATA_BYTES,
  parameter int MAX_BYTES  = xb_pkg::XB_MAX_BYTES,
  localparam int UP_W      = ADDR_W - OFFSET_W,
  localparam int IDX_W     = $clog2(REGIONS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mode_root,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [UP_W-1:0]    cfg_upper,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [IDX_W-1:0]   req_region,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [BEATS_W-1:0] req_beats,
  input  logic [TAG_W-1:0]   req_tag,
  input  logic               req_bad,
  output logic               m_valid,
  output logic               m_write,
  output logic [ADDR_W-1:0]  m_addr,
  output logic [BEATS_W-1:0] m_burst,
  output logic [TAG_W-1:0]   m_tag,
  input  logic               m_wait,
  output logic               abort_valid,
  output logic [TAG_W-1:0]   abort_tag
);
  import xb_pkg::*;

  logic              accept;
  disp_e             disp;
  logic [ADDR_W-1:0] local_addr;

  assign req_ready = !m_valid;
  assign accept    = req_valid && req_ready;

  always_comb begin
    if (!req_bad)      disp = DISP_CMD;
    else if (req_write) disp = DISP_DROP;
    else               disp = DISP_ABORT;
  end

  xb_xlate_table #(
    .ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .REGIONS(REGIONS)
  ) u_table (
    .clk(clk), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_upper(cfg_upper),
    .root_mode(mode_root), .region(req_region), .addr_in(req_addr),
    .addr_out(local_addr)
  );

  xb_cmd_seq #(
    .ADDR_W(ADDR_W), .BEATS_W(BEATS_W), .TAG_W(TAG_W),
    .DATA_BYTES(DATA_BYTES), .MAX_BYTES(MAX_BYTES)
  ) u_seq (
    .clk(clk), .rst(rst),
    .load(accept && disp == DISP_CMD),
    .ld_write(req_write), .ld_addr(local_addr), .ld_beats(req_beats),
    .ld_tag(req_tag), .m_wait(m_wait),
    .m_valid(m_valid), .m_write(m_write), .m_addr(m_addr),
    .m_burst(m_burst), .m_tag(m_tag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      abort_valid <= 1'b0;
      abort_tag   <= '0;
    end else begin
      abort_valid <= accept && disp == DISP_ABORT;
      if (accept && disp == DISP_ABORT) abort_tag <= req_tag;
    end
  end

  p_drop_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (accept && req_write && req_bad) |=> (!m_valid && !abort_valid));

  p_abort_tag_r5: assert property (@(posedge clk) disable iff (rst)
    (accept && !req_write && req_bad) |=> (abort_valid && abort_tag == $past(req_tag)));

  p_abort_nocmd_r5: assert property (@(posedge clk) disable iff (rst)
    abort_valid |-> !m_valid);

  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    (accept && !req_bad) |=> (m_valid && m_tag == $past(req_tag)));
endmodule

// File: tb/req_xlate_bridge_tb.sv
module req_xlate_bridge_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_root = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [11:0] cfg_upper = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [2:0]  req_region = '0;
  logic [31:0] req_addr = '0;
  logic [9:0]  req_beats = '0;
  logic [7:0]  req_tag = '0;
  logic        req_bad = 1'b0;
  logic        m_valid, m_write;
  logic [31:0] m_addr;
  logic [9:0]  m_burst;
  logic [7:0]  m_tag;
  logic        m_wait = 1'b0;
  logic        abort_valid;
  logic [7:0]  abort_tag;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  req_xlate_bridge u_dut (
    .clk(clk), .rst(rst), .mode_root(mode_root),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_upper(cfg_upper),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_region(req_region), .req_addr(req_addr), .req_beats(req_beats),
    .req_tag(req_tag), .req_bad(req_bad),
    .m_valid(m_valid), .m_write(m_write), .m_addr(m_addr), .m_burst(m_burst),
    .m_tag(m_tag), .m_wait(m_wait),
    .abort_valid(abort_valid), .abort_tag(abort_tag)
  );

  function automatic logic [11:0] up_of(input int i);
    return 12'h3C0 ^ 12'(i * 12'h111);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic send(input bit wr, input logic [2:0] rg, input logic [31:0] a,
                      input logic [9:0] beats, input logic [7:0] tag, input bit bad);
    @(negedge clk);
    req_write = wr; req_region = rg; req_addr = a; req_beats = beats;
    req_tag = tag; req_bad = bad; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Waits for a burst, stalls it for 'stalls' cycles, then compares it.
  task automatic get_burst(input string req, input logic [31:0] ea, input logic [9:0] eb,
                           input bit ew, input logic [7:0] et, input int stalls);
    int n = 0;
    int guard = 0;
    logic [31:0] sa = '0;
    logic [9:0]  sb = '0;
    while (1) begin
      if (m_valid) begin
        if (n < stalls) begin
          if (n > 0) begin
            chk(m_addr == sa && m_burst == sb, "R9", "held during stall",
                {m_addr, 22'(m_burst)}, {sa, 22'(sb)});
            chk(req_ready == 1'b0, "R10", "ready while busy", 64'(req_ready), 64'd0);
          end
          sa = m_addr; sb = m_burst;
          m_wait = 1'b1;
          n++;
        end else begin
          m_wait = 1'b0;
          chk(m_addr == ea, req, "burst addr", 64'(m_addr), 64'(ea));
          chk(m_burst == eb, req, "burst beats", 64'(m_burst), 64'(eb));
          chk(m_write == ew, req, "burst dir", 64'(m_write), 64'(ew));
          chk(m_tag == et, req, "burst tag", 64'(m_tag), 64'(et));
          break;
        end
      end
      guard++;
      if (guard > 200) begin
        chk(1'b0, req, "no burst seen", 64'd0, 64'd1);
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic expect_idle(input string req);
    chk(m_valid == 1'b0, req, "idle valid", 64'(m_valid), 64'd0);
    chk(req_ready == 1'b1, req, "idle ready", 64'(req_ready), 64'd1);
  endtask

  task automatic t_reset();
    chk(m_valid == 1'b0, "R1", "reset m_valid", 64'(m_valid), 64'd0);
    chk(abort_valid == 1'b0, "R1", "reset abort", 64'(abort_valid), 64'd0);
    chk(req_ready == 1'b1, "R1", "reset ready", 64'(req_ready), 64'd1);
  endtask

  task automatic t_config();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = 3'(i); cfg_upper = up_of(i);
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic t_ep_read();  // R2 and R7: single 128-beat read
    send(1'b0, 3'd2, 32'h5550_1230, 10'd128, 8'h21, 1'b0);
    get_burst("R2", {up_of(2), 20'h01230}, 10'd128, 1'b0, 8'h21, 0);
    expect_idle("R7");
    send(1'b0, 3'd6, 32'h0000_0FFC, 10'd1, 8'h22, 1'b0);
    get_burst("R7", {up_of(6), 20'h00FFC}, 10'd1, 1'b0, 8'h22, 0);
    expect_idle("R7");
  endtask

  task automatic t_write_long();  // R6: write not split, with stalls (R9)
    send(1'b1, 3'd7, 32'hFFFF_8000, 10'd300, 8'h33, 1'b0);
    get_burst("R6", {up_of(7), 20'hF8000}, 10'd300, 1'b1, 8'h33, 3);
    expect_idle("R6");
  endtask

  task automatic t_split(input logic [9:0] beats, input logic [7:0] tag);  // R8
    logic [31:0] a = {up_of(5), 20'h12340};
    int left = int'(beats);
    int k = 0;
    send(1'b0, 3'd5, 32'h0001_2340, beats, tag, 1'b0);
    while (left > 0) begin
      int c = (left > 128) ? 128 : left;
      get_burst("R8", a, 10'(c), 1'b0, tag, (k == 0) ? 3 : 1);
      a = a + 32'(c * 4);
      left -= c;
      k++;
    end
    expect_idle("R8");
  endtask

  task automatic t_drop();  // R4
    send(1'b1, 3'd1, 32'h0000_4000, 10'd4, 8'h44, 1'b1);
    for (int i = 0; i < 4; i++) begin
      chk(m_valid == 1'b0 && abort_valid == 1'b0, "R4", "dropped write activity",
          64'({m_valid, abort_valid}), 64'd0);
      chk(req_ready == 1'b1, "R4", "ready after drop", 64'(req_ready), 64'd1);
      @(negedge clk);
    end
  endtask

  task automatic t_abort();  // R5
    send(1'b0, 3'd3, 32'h0000_8000, 10'd8, 8'h5A, 1'b1);
    chk(abort_valid == 1'b1 && abort_tag == 8'h5A, "R5", "abort pulse",
        64'({abort_valid, abort_tag}), 64'h15A);
    chk(m_valid == 1'b0, "R5", "no command on abort", 64'(m_valid), 64'd0);
    @(negedge clk);
    chk(abort_valid == 1'b0, "R5", "abort one cycle", 64'(abort_valid), 64'd0);
    chk(m_valid == 1'b0, "R5", "no late command", 64'(m_valid), 64'd0);
  endtask

  task automatic t_abort_pair();  // R11
    @(negedge clk);
    req_write = 1'b0; req_bad = 1'b1; req_tag = 8'hA1; req_valid = 1'b1;
    @(negedge clk);
    req_tag = 8'hA2;
    chk(abort_valid && abort_tag == 8'hA1, "R11", "first abort",
        64'({abort_valid, abort_tag}), 64'h1A1);
    @(negedge clk);
    req_valid = 1'b0; req_bad = 1'b0;
    chk(abort_valid && abort_tag == 8'hA2, "R11", "second abort",
        64'({abort_valid, abort_tag}), 64'h1A2);
    @(negedge clk);
    chk(abort_valid == 1'b0, "R11", "aborts end", 64'(abort_valid), 64'd0);
  endtask

  task automatic t_root();  // R3
    @(negedge clk);
    mode_root = 1'b1;
    send(1'b0, 3'd5, 32'h1234_5670, 10'd10, 8'h66, 1'b0);
    get_burst("R3", 32'h1234_5670, 10'd10, 1'b0, 8'h66, 0);
    send(1'b1, 3'd0, 32'h8765_4320, 10'd2, 8'h67, 1'b0);
    get_burst("R3", 32'h8765_4320, 10'd2, 1'b1, 8'h67, 0);
    @(negedge clk);
    mode_root = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_config();
    t_ep_read();
    t_write_long();
    t_split(10'd300, 8'h77);
    t_split(10'd256, 8'h78);
    t_drop();
    t_abort();
    t_abort_pair();
    t_root();
    t_ep_read();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule